// File: doc/BRIEF.md
# AHB-Lite Wait-State and Error Responder

This block is a synthesizable AHB-Lite subordinate meant to put bus managers under pressure. It keeps a small word-addressed store built from flip-flops. Each active transfer gets a programmable number of wait states. Addresses inside a programmable window finish with the two-cycle ERROR response. Data phases that carry no transfer always finish at once with OKAY.

Each transfer is tracked by a five-state response machine:

- `RS_IDLE`: the data phase is empty. The block drives ready high and response low.
- `RS_WAIT`: the block inserts stall cycles. It drives ready low and response low.
- `RS_OKAY`: a transfer completes. It drives ready high and response low.
- `RS_ERR_HOLD`: first ERROR cycle. It drives ready low and response high.
- `RS_ERR_DONE`: second ERROR cycle. It drives ready high and response high.

Transitions:

- From `RS_IDLE`, `RS_OKAY` or `RS_ERR_DONE`, a bus edge with `hready` high samples the address phase:
  - no transfer goes to `RS_IDLE`;
  - a transfer with a nonzero capped wait count goes to `RS_WAIT`;
  - otherwise the machine goes straight to `RS_OKAY` or `RS_ERR_HOLD`.
- `RS_WAIT` counts down. On its last stall it moves to `RS_OKAY` or `RS_ERR_HOLD`.
- `RS_ERR_HOLD` always moves to `RS_ERR_DONE`.

The wait count and the error window come from sideband inputs. The stall bound comes from the parameter `MAX_STALL`. A negative `MAX_STALL` removes both the cap and its monitor.

Top module: `ahb_stall_responder`

## Requirements
- R1: Address-phase information is sampled into the data-phase registers only on an edge where `hready` is high. A transfer offered while `hready` is low is ignored, and the data phase that follows finishes as an idle one.
- R2: While the data phase holds no transfer, `hready_resp` is 1 and `hresp` is 0 in that same cycle.
- R3: A transfer outside the error window shows exactly Wo cycles of `hready_resp`=0 and `hresp`=0. It then shows one cycle with `hready_resp`=1 and `hresp`=0. Wo = min(`cfg_wait`, `MAX_STALL`).
- R4: A transfer whose address satisfies `cfg_err_lo` <= `haddr` <= `cfg_err_hi`, with `cfg_err_en`=1, first shows We stall cycles with response low, where We = min(`cfg_wait`, `MAX_STALL`-1). It then shows one cycle with `hresp`=1 and `hready_resp`=0, followed by one cycle with `hresp`=1 and `hready_resp`=1.
- R5: A cycle with `hresp`=1 and `hready_resp`=1 is always directly preceded by a cycle with `hresp`=1 and `hready_resp`=0.
- R6: A cycle with `hresp`=1 and `hready_resp`=0 is always directly followed by a cycle with `hresp`=1 and `hready_resp`=1.
- R7: A saturating 8-bit counter of consecutive `hready`-low cycles never exceeds `MAX_STALL` when `MAX_STALL` >= 0. A bounded `MAX_STALL` must be at least 1.
- R8: Writes use byte lanes, where lane k is bits [8k+7:8k] and lanes outside the size are kept.
  - `hsize` 0 writes lane `haddr[1:0]`.
  - `hsize` 1 writes lanes 2*`haddr[1]` and 2*`haddr[1]`+1.
  - `hsize` 2 writes all four lanes.
  - The word index is `haddr[IDXW+1:2]`, and higher address bits alias.
- R9: `hrdata` carries the addressed word in the completing OKAY cycle of a read and is zero in every other cycle.
- R10: A transfer that ends in ERROR leaves the store unchanged.
- R11: `hexokay` is 0 in every cycle.
- R12: An active-low `rst_n` acts asynchronously. It returns the block to `RS_IDLE` (`hready_resp`=1, `hresp`=0) at once and clears every stored word to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| haddr | input | AW | Address-phase byte address |
| hwrite | input | 1 | Address-phase write flag |
| htrans | input | 2 | Transfer type; bit 1 marks an active transfer |
| hsize | input | 3 | Transfer size: 0 byte, 1 halfword, 2 word |
| hburst | input | 3 | Burst type, not used |
| hprot | input | 4 | Protection attributes, not used |
| hmastlock | input | 1 | Locked-sequence flag, not used |
| hwdata | input | DW | Write data, valid in the data phase |
| hready | input | 1 | Bus-wide ready that ends a data phase |
| cfg_wait | input | WAIT_W | Requested wait states per transfer |
| cfg_err_en | input | 1 | Enables the error window |
| cfg_err_lo | input | AW | Lowest erroring byte address, inclusive |
| cfg_err_hi | input | AW | Highest erroring byte address, inclusive |
| hrdata | output | DW | Read data |
| hready_resp | output | 1 | Ready driven by this subordinate |
| hresp | output | 1 | 1 signals ERROR |
| hexokay | output | 1 | Exclusive-okay, held low |

## Verification
The end of one data phase and the sampling of the next address phase share a cycle. A write commit, or the second ERROR cycle, therefore coincides with the capture of a new transfer. The bench drives a fully pipelined stream in which every write is followed at once by a read of the same word, and erroring writes are followed directly by further transfers. It sweeps the wait setting across and past the cap, with the window switched on and off. Each cycle's ready and response pair is compared with the shape predicted arithmetically from the wait count, the cap and the window. Every read is compared against a byte-lane scoreboard.

// File: rtl/ahbr_pkg.sv
package ahbr_pkg;

    typedef enum logic [2:0] {
        RS_IDLE     = 3'd0,
        RS_WAIT     = 3'd1,
        RS_OKAY     = 3'd2,
        RS_ERR_HOLD = 3'd3,
        RS_ERR_DONE = 3'd4
    } resp_state_t;

    typedef struct packed {
        logic       active;
        logic       write;
        logic       err;
        logic [2:0] size;
    } dp_ctl_t;

endpackage

// File: rtl/ahbr_dphase.sv
module ahbr_dphase #(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hready,
    input  logic [1:0]        htrans,
    input  logic              hwrite,
    input  logic [AW-1:0]     haddr,
    input  logic [2:0]        hsize,
    input  logic              cfg_err_en,
    input  logic [AW-1:0]     cfg_err_lo,
    input  logic [AW-1:0]     cfg_err_hi,
    output logic              ap_active,
    output logic              ap_err,
    output ahbr_pkg::dp_ctl_t dp_ctl,
    output logic [AW-1:0]     dp_addr
);

    logic unused_seq_bit;

    assign ap_active      = htrans[1];
    assign ap_err         = cfg_err_en && (haddr >= cfg_err_lo) && (haddr <= cfg_err_hi);
    assign unused_seq_bit = htrans[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp_ctl  <= '0;
            dp_addr <= '0;
        end else if (hready) begin
            dp_ctl.active <= ap_active;
            dp_ctl.write  <= hwrite;
            dp_ctl.err    <= ap_err;
            dp_ctl.size   <= hsize;
            dp_addr       <= haddr;
        end
    end

    AST_DP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !hready |=> ($stable(dp_addr) && $stable(dp_ctl))); // R1

endmodule

// File: rtl/ahbr_resp_fsm.sv
module ahbr_resp_fsm #(
    parameter int MAX_STALL = 6,
    parameter int WAIT_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hready,
    input  logic              ap_active,
    input  logic              ap_err,
    input  logic              dp_err,
    input  logic [WAIT_W-1:0] cfg_wait,
    output logic              hready_resp,
    output logic              hresp,
    output logic              ok_done
);
    import ahbr_pkg::*;

    localparam bit BOUNDED  = (MAX_STALL >= 0);
    localparam int WAIT_MAX = (1 << WAIT_W) - 1;
    localparam int OK_LIM   = !BOUNDED ? WAIT_MAX :
                              (MAX_STALL < WAIT_MAX) ? MAX_STALL : WAIT_MAX;
    localparam int ERR_LIM  = !BOUNDED ? WAIT_MAX :
                              (MAX_STALL == 0) ? 0 :
                              (MAX_STALL - 1 < WAIT_MAX) ? MAX_STALL - 1 : WAIT_MAX;
    localparam logic [WAIT_W-1:0] OK_CAP  = WAIT_W'(OK_LIM);
    localparam logic [WAIT_W-1:0] ERR_CAP = WAIT_W'(ERR_LIM);

    resp_state_t       state_q, state_d;
    logic [WAIT_W-1:0] wait_q, wait_d;
    logic [WAIT_W-1:0] ok_waits, err_waits;

    assign ok_waits  = (cfg_wait > OK_CAP)  ? OK_CAP  : cfg_wait;
    assign err_waits = (cfg_wait > ERR_CAP) ? ERR_CAP : cfg_wait;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RS_IDLE;
            wait_q  <= '0;
        end else begin
            state_q <= state_d;
            wait_q  <= wait_d;
        end
    end

    always_comb begin
        state_d = state_q;
        wait_d  = wait_q;
        unique case (state_q)
            RS_WAIT: begin
                if (wait_q == WAIT_W'(1)) begin
                    wait_d  = '0;
                    state_d = dp_err ? RS_ERR_HOLD : RS_OKAY;
                end else begin
                    wait_d = wait_q - 1'b1;
                end
            end
            RS_ERR_HOLD: state_d = RS_ERR_DONE;
            RS_IDLE, RS_OKAY, RS_ERR_DONE: begin
                if (hready) begin
                    if (!ap_active) begin
                        state_d = RS_IDLE;
                    end else if (ap_err) begin
                        if (err_waits != '0) begin
                            state_d = RS_WAIT;
                            wait_d  = err_waits;
                        end else begin
                            state_d = RS_ERR_HOLD;
                        end
                    end else if (ok_waits != '0) begin
                        state_d = RS_WAIT;
                        wait_d  = ok_waits;
                    end else begin
                        state_d = RS_OKAY;
                    end
                end
            end
            default: begin
                state_d = RS_IDLE;
                wait_d  = '0;
            end
        endcase
    end

    always_comb begin
        unique case (state_q)
            RS_IDLE:     begin hready_resp = 1'b1; hresp = 1'b0; end
            RS_WAIT:     begin hready_resp = 1'b0; hresp = 1'b0; end
            RS_OKAY:     begin hready_resp = 1'b1; hresp = 1'b0; end
            RS_ERR_HOLD: begin hready_resp = 1'b0; hresp = 1'b1; end
            RS_ERR_DONE: begin hready_resp = 1'b1; hresp = 1'b1; end
            default:     begin hready_resp = 1'b1; hresp = 1'b0; end
        endcase
    end

    assign ok_done = (state_q == RS_OKAY);

    generate
        if (BOUNDED) begin : g_stall_mon
            logic [7:0] stall_run;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stall_run <= '0;
                end else if (hready) begin
                    stall_run <= '0;
                end else if (stall_run != 8'hFF) begin
                    stall_run <= stall_run + 8'd1;
                end
            end

            AST_STALL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
                int'(stall_run) <= MAX_STALL); // R7
        end
    endgenerate

    AST_ERR_DONE_PRECEDED: assert property (@(posedge clk) disable iff (!rst_n)
        (hresp && hready_resp) |-> $past(hresp && !hready_resp)); // R5

    AST_ERR_HOLD_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (hresp && !hready_resp) |=> (hresp && hready_resp)); // R6

endmodule

// File: rtl/ahbr_word_mem.sv
module ahbr_word_mem #(
    parameter int DW    = 32,
    parameter int WORDS = 16,
    localparam int NB   = DW / 8,
    localparam int OFFW = $clog2(NB),
    localparam int IDXW = $clog2(WORDS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [IDXW-1:0] idx,
    input  logic [OFFW-1:0] off,
    input  logic [2:0]      size,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata
);

    logic [NB-1:0] lane_en;
    logic [DW-1:0] word_all [WORDS];

    always_comb begin
        int span;
        int base;
        span = (int'(size) >= OFFW) ? NB : (1 << int'(size));
        base = int'(off) & ~(span - 1);
        for (int b = 0; b < NB; b++) begin
            lane_en[b] = (b >= base) && (b < base + span);
        end
    end

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        logic [DW-1:0] word_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (we && (idx == IDXW'(g))) begin
                for (int b = 0; b < NB; b++) begin
                    if (lane_en[b]) word_q[8*b +: 8] <= wdata[8*b +: 8];
                end
            end
        end
        assign word_all[g] = word_q;
    end

    assign rdata = word_all[idx];

endmodule

// File: rtl/ahb_stall_responder.sv
module ahb_stall_responder #(
    parameter int AW        = 32,
    parameter int DW        = 32,
    parameter int WORDS     = 16,
    parameter int MAX_STALL = 6,
    parameter int WAIT_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     haddr,
    input  logic              hwrite,
    input  logic [1:0]        htrans,
    input  logic [2:0]        hsize,
    input  logic [2:0]        hburst,
    input  logic [3:0]        hprot,
    input  logic              hmastlock,
    input  logic [DW-1:0]     hwdata,
    input  logic              hready,
    input  logic [WAIT_W-1:0] cfg_wait,
    input  logic              cfg_err_en,
    input  logic [AW-1:0]     cfg_err_lo,
    input  logic [AW-1:0]     cfg_err_hi,
    output logic [DW-1:0]     hrdata,
    output logic              hready_resp,
    output logic              hresp,
    output logic              hexokay
);
    import ahbr_pkg::*;

    localparam int NB   = DW / 8;
    localparam int OFFW = $clog2(NB);
    localparam int IDXW = $clog2(WORDS);

    logic          ap_active, ap_err, ok_done, mem_we;
    dp_ctl_t       dp_ctl;
    logic [AW-1:0] dp_addr;
    logic [DW-1:0] mem_rdata;
    logic          unused_bus;

    ahbr_dphase #(.AW(AW)) u_dphase (
        .clk        (clk),
        .rst_n      (rst_n),
        .hready     (hready),
        .htrans     (htrans),
        .hwrite     (hwrite),
        .haddr      (haddr),
        .hsize      (hsize),
        .cfg_err_en (cfg_err_en),
        .cfg_err_lo (cfg_err_lo),
        .cfg_err_hi (cfg_err_hi),
        .ap_active  (ap_active),
        .ap_err     (ap_err),
        .dp_ctl     (dp_ctl),
        .dp_addr    (dp_addr)
    );

    ahbr_resp_fsm #(.MAX_STALL(MAX_STALL), .WAIT_W(WAIT_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .hready      (hready),
        .ap_active   (ap_active),
        .ap_err      (ap_err),
        .dp_err      (dp_ctl.err),
        .cfg_wait    (cfg_wait),
        .hready_resp (hready_resp),
        .hresp       (hresp),
        .ok_done     (ok_done)
    );

    assign mem_we = ok_done && hready && dp_ctl.write;

    ahbr_word_mem #(.DW(DW), .WORDS(WORDS)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .idx   (dp_addr[OFFW +: IDXW]),
        .off   (dp_addr[OFFW-1:0]),
        .size  (dp_ctl.size),
        .wdata (hwdata),
        .rdata (mem_rdata)
    );

    assign hrdata     = (ok_done && !dp_ctl.write) ? mem_rdata : '0;
    assign hexokay    = 1'b0;
    assign unused_bus = ^{hburst, hprot, hmastlock, dp_addr[AW-1:OFFW+IDXW]};

    AST_IDLE_ZERO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        !dp_ctl.active |-> (hready_resp && !hresp)); // R2

    AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        hresp |-> !mem_we); // R10

    AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(hready_resp && !hresp && dp_ctl.active && !dp_ctl.write) |-> (hrdata == '0)); // R9

endmodule

// File: tb/ahb_stall_responder_tb_top.sv
module ahb_stall_responder_tb_top;

    localparam int CAP = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] haddr = '0;
    logic        hwrite = 1'b0;
    logic [1:0]  htrans = 2'b00;
    logic [2:0]  hsize = 3'd0;
    logic [2:0]  hburst = 3'd0;
    logic [3:0]  hprot = 4'd0;
    logic        hmastlock = 1'b0;
    logic [31:0] hwdata = '0;
    logic        hold_off = 1'b0;
    logic [7:0]  cfg_wait = '0;
    logic        cfg_err_en = 1'b0;
    logic [31:0] cfg_err_lo = 32'h14;
    logic [31:0] cfg_err_hi = 32'h1B;
    logic [31:0] hrdata;
    logic        hready_resp, hresp, hexokay;
    logic        hready;

    assign hready = hready_resp & ~hold_off;

    always #2 clk = ~clk;

    ahb_stall_responder #(.AW(32), .DW(32), .WORDS(8), .MAX_STALL(CAP), .WAIT_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .haddr(haddr), .hwrite(hwrite), .htrans(htrans),
        .hsize(hsize), .hburst(hburst), .hprot(hprot), .hmastlock(hmastlock),
        .hwdata(hwdata), .hready(hready), .cfg_wait(cfg_wait), .cfg_err_en(cfg_err_en),
        .cfg_err_lo(cfg_err_lo), .cfg_err_hi(cfg_err_hi), .hrdata(hrdata),
        .hready_resp(hready_resp), .hresp(hresp), .hexokay(hexokay)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [31:0] mdl [8];
    int          q_kind [256];
    logic [31:0] q_addr [256];
    logic [31:0] q_data [256];
    logic [2:0]  q_size [256];
    int          q_n = 0;
    int          a_kind;
    logic [31:0] a_addr, a_data;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic push(input int kind, input logic [31:0] addr, input logic [2:0] sz, input logic [31:0] d);
        q_kind[q_n] = kind; q_addr[q_n] = addr; q_size[q_n] = sz; q_data[q_n] = d;
        q_n++;
    endtask

    task automatic present(input int i);
        if (i < q_n && q_kind[i] != 0) begin
            htrans = 2'b10; hwrite = (q_kind[i] == 2); haddr = q_addr[i]; hsize = q_size[i];
            a_kind = q_kind[i]; a_addr = q_addr[i]; a_data = q_data[i];
        end else begin
            htrans = 2'b00; hwrite = 1'b0; haddr = '0; hsize = 3'd0;
            a_kind = 0; a_addr = '0; a_data = '0;
        end
    endtask

    function automatic bit in_window(input logic [31:0] addr);
        return cfg_err_en && (addr >= cfg_err_lo) && (addr <= cfg_err_hi);
    endfunction

    function automatic void mdl_write(input logic [31:0] addr, input logic [2:0] sz, input logic [31:0] d);
        int span;
        int base;
        int w;
        span = 1 << int'(sz);
        base = int'(addr[1:0]) & ~(span - 1);
        w    = int'(addr[4:2]);
        for (int b = 0; b < 4; b++) begin
            if (b >= base && b < base + span) mdl[w][8*b +: 8] = d[8*b +: 8];
        end
    endfunction

    task automatic run_seq();
        int          nxt = 0;
        bit          dvalid = 0;
        int          dk = 0;
        logic [31:0] daddr = '0, dd = '0;
        logic [2:0]  dsz = '0;
        bit          derr = 0;
        int          cyc = 0;
        int          lowrun = 0;
        int          wo, we, w;
        bit          er, ep;
        logic [31:0] erd;
        string       tag;
        wo = (int'(cfg_wait) < CAP) ? int'(cfg_wait) : CAP;
        we = (int'(cfg_wait) < CAP - 1) ? int'(cfg_wait) : CAP - 1;
        @(posedge clk); #1;
        present(nxt); nxt++;
        forever begin
            @(negedge clk);
            if (!dvalid) begin
                er = 1; ep = 0; tag = "R2 idle data phase";
            end else if (derr) begin
                w = we; tag = "R4 R5 R6 error shape";
                if (cyc < w) begin er = 0; ep = 0; end
                else begin ep = 1; er = (cyc == w + 1); end
            end else begin
                w = wo; tag = "R3 okay shape";
                er = (cyc >= w); ep = 0;
            end
            chk({hready_resp, hresp} == {er, ep}, tag, {hready_resp, hresp}, {er, ep});
            erd = (dvalid && !derr && dk == 1 && er) ? mdl[daddr[4:2]] : 32'h0;
            chk(hrdata == erd, "R8 R9 R10 read data", hrdata, erd);
            chk(hexokay == 1'b0, "R11 exokay", hexokay, 0);
            lowrun = hready_resp ? 0 : lowrun + 1;
            chk(lowrun <= CAP, "R7 stall run", lowrun, CAP);
            if (!dvalid && nxt > q_n) break;
            @(posedge clk);
            if (er) begin
                if (dvalid && !derr && dk == 2) mdl_write(daddr, dsz, dd);
                dvalid = (a_kind != 0); dk = a_kind; daddr = a_addr; dd = a_data;
                dsz = hsize; derr = in_window(a_addr); cyc = 0;
            end else begin
                cyc++;
            end
            #1;
            if (er) begin
                hwdata = (dk == 2) ? dd : 32'h0;
                present(nxt); nxt++;
            end
        end
    endtask

    initial begin
        for (int i = 0; i < 8; i++) mdl[i] = '0;
        #3;
        chk(hready_resp == 1'b1 && hresp == 1'b0, "R12 reset state", {hready_resp, hresp}, 2'b10);
        chk(hexokay == 1'b0, "R11 exokay in reset", hexokay, 0);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        for (int wv = 0; wv < 6; wv++) begin
            cfg_wait = 8'(wv);
            cfg_err_en = wv[0];
            q_n = 0;
            for (int k = 0; k < 8; k++) begin
                for (int v = 0; v < 7; v++) begin
                    int lane;
                    logic [2:0] sz;
                    if (v < 4) begin sz = 3'd0; lane = v; end
                    else if (v < 6) begin sz = 3'd1; lane = (v - 4) * 2; end
                    else begin sz = 3'd2; lane = 0; end
                    push(2, 32'(k * 4 + lane), sz, 32'h9E3779B9 * 32'(wv * 64 + k * 8 + v + 1));
                    push(1, 32'(k * 4 + (wv[1] ? 32 : 0)), 3'd2, '0);
                end
                if (k % 2 == 1) push(0, '0, 3'd0, '0);
            end
            run_seq();
        end

        // R1: an address phase offered while hready is low is dropped
        cfg_wait = 8'd1; cfg_err_en = 1'b0;
        @(posedge clk); #1;
        hold_off = 1'b1; htrans = 2'b10; hwrite = 1'b1; haddr = 32'h0; hsize = 3'd2;
        @(negedge clk);
        chk(hready_resp && !hresp, "R1 idle while offer held off", {hready_resp, hresp}, 2'b10);
        @(posedge clk); #1;
        hold_off = 1'b0; htrans = 2'b00; hwrite = 1'b0; hwdata = 32'hDEADBEEF;
        @(negedge clk);
        chk(hready_resp && !hresp, "R1 dropped transfer gives idle phase", {hready_resp, hresp}, 2'b10);
        q_n = 0;
        push(1, 32'h0, 3'd2, '0);
        run_seq();

        // R12: asynchronous reset in the middle of a stall
        cfg_wait = 8'd3;
        @(posedge clk); #1;
        htrans = 2'b10; hwrite = 1'b1; haddr = 32'h4; hsize = 3'd2;
        @(posedge clk); #1;
        htrans = 2'b00; hwrite = 1'b0; hwdata = 32'h12345678;
        chk(hready_resp == 1'b0, "R3 stall before reset", hready_resp, 0);
        rst_n = 1'b0;
        #1;
        chk(hready_resp == 1'b1 && hresp == 1'b0, "R12 async reset", {hready_resp, hresp}, 2'b10);
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        for (int i = 0; i < 8; i++) mdl[i] = '0;
        q_n = 0;
        for (int i = 0; i < 8; i++) push(1, 32'(i * 4), 3'd2, '0);
        run_seq();

        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 50000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R3 act=hung exp=done");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule